// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block counts position from a two-channel incremental encoder (inputs A and B) or, when no encoder is selected, counts clock cycles. A two-bit mode field picks one of four behaviours: free counting on the internal clock, double-resolution counting on the transitions of A, double-resolution counting on the transitions of B, or quadruple-resolution counting on the transitions of both. The count runs between 0 and a programmable ceiling and wraps at either end. A status bit shows which way the most recent step went.

Software reaches the block through a small single-cycle register port. Writes are taken on the clock edge where `wr_en` is high. Reads are combinational from `addr`. The ceiling has a shadow copy. With preload off, a written ceiling applies at once. With preload on, it applies only at the next update event. An update event is either a counter wrap or a software request. The encoder inputs first pass through a two-flop synchronizer. A phase state machine then decodes them. Its states are PH_00, PH_10, PH_11 and PH_01, named by the sampled {A,B} pair. Each sample gives one of four transitions: TR_FWD (the next phase in the order 00→10→11→01→00), TR_REV (the previous phase), TR_NONE (same phase) or TR_BAD (both inputs changed together).

Top module: `qenc_counter`

## Requirements
- R1: With mode 0 and the run bit set, the count rises by one on every clock cycle.
- R2: With mode 1, only changes of A are counted. The step is up when the new level of A differs from B and down otherwise. Changes of B do not count.
- R3: With mode 2, only changes of B are counted. The step is up when the new level of B equals A and down otherwise. Changes of A do not count.
- R4: With mode 3, every legal change of A or B counts, so one full quadrature cycle gives four steps. Forward order is {A,B} = 00,10,11,01.
- R5: While the run bit is 0, the count holds its value.
- R6: Each input passes through two synchronizer flops. A change that reaches the count does so on the third rising edge after the input changes. A sample in which A and B both changed produces no step.
- R7: With preload (control bit 1) clear, a ceiling write takes effect on the next edge. With preload set, the active ceiling changes only on an update event. The ceiling register reads back the last value written.
- R8: An up step from a count at or above the ceiling gives 0. A down step from 0 gives the ceiling. Either wrap is an update event.
- R9: A count write whose value exceeds the active ceiling is ignored. A write at or below the ceiling loads the count. A count write takes priority over a step in the same cycle.
- R10: Writing 1 to bit 0 of the event register (address 4) raises an update event. That register always reads 0.
- R11: Control bit 4 is read-only. It reads 1 after a down step and 0 after an up step. Free counting reports up.
- R12: Reset clears the count, mode, run, preload and direction bits, and sets the ceiling to all ones.
- R13: Register map: address 0 is control (bit 0 run, bit 1 preload, bit 4 direction); address 1 is the mode in bits 1:0; address 2 is the count; address 3 is the ceiling; address 4 is the event register. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr` |
| qa_in | input | 1 | Encoder channel A (asynchronous) |
| qb_in | input | 1 | Encoder channel B (asynchronous) |

## Verification
The same forward and reverse quadrature walks are run in each encoder mode. Because the two x2 modes react to different halves of one sequence, the counts they reach show which input each one honours. A walk that crosses zero shows that the down wrap lands on the ceiling. A pattern where both inputs flip together, followed by one legal step, shows that illegal samples are dropped while the phase tracking stays aligned. Free counting with a preloaded ceiling gives different counts from an immediate ceiling within a few cycles, which shows when the active ceiling changes. Count writes just above and just below the ceiling, with and without a software event, show which ceiling the write is judged against.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam int ADDR_W       = 3;
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_PRE_BIT = 1;
    localparam int CTRL_DIR_BIT = 4;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_X2A  = 2'd1,
        MODE_X2B  = 2'd2,
        MODE_X4   = 2'd3
    } cnt_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_MODE  = 3'd1,
        REG_COUNT = 3'd2,
        REG_CEIL  = 3'd3,
        REG_EVENT = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        TR_NONE,
        TR_FWD,
        TR_REV,
        TR_BAD
    } quad_tr_e;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_out
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            logic [STAGES-1:0] shreg;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shreg <= '0;
                end else begin
                    shreg <= {shreg[STAGES-2:0], d_in[gi]};
                end
            end
            assign d_out[gi] = shreg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a_s,
    input  logic      b_s,
    input  cnt_mode_e mode,
    output logic      step,
    output logic      down
);

    phase_e   phase_q;
    quad_tr_e tr;
    logic [1:0] cur;
    logic [1:0] prev;
    logic a_moved;
    logic b_moved;
    logic legal;

    assign cur     = {a_s, b_s};
    assign prev    = phase_q;
    assign a_moved = prev[1] ^ a_s;
    assign b_moved = prev[0] ^ b_s;

    // State register: phase follows the sampled pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_00;
        end else begin
            phase_q <= phase_e'(cur);
        end
    end

    // Transition classification
    always_comb begin
        tr = TR_NONE;
        unique case (phase_q)
            PH_00: begin
                if (cur == 2'b10)      tr = TR_FWD;
                else if (cur == 2'b01) tr = TR_REV;
                else if (cur == 2'b11) tr = TR_BAD;
            end
            PH_10: begin
                if (cur == 2'b11)      tr = TR_FWD;
                else if (cur == 2'b00) tr = TR_REV;
                else if (cur == 2'b01) tr = TR_BAD;
            end
            PH_11: begin
                if (cur == 2'b01)      tr = TR_FWD;
                else if (cur == 2'b10) tr = TR_REV;
                else if (cur == 2'b00) tr = TR_BAD;
            end
            PH_01: begin
                if (cur == 2'b00)      tr = TR_FWD;
                else if (cur == 2'b11) tr = TR_REV;
                else if (cur == 2'b10) tr = TR_BAD;
            end
            default: tr = TR_NONE;
        endcase
    end

    assign legal = (tr == TR_FWD) || (tr == TR_REV);

    // Outputs: mode filters which input edges produce a step
    always_comb begin
        step = 1'b0;
        down = 1'b0;
        unique case (mode)
            MODE_FREE: begin
                step = 1'b1;
                down = 1'b0;
            end
            MODE_X2A: begin
                step = legal && a_moved;
                down = (tr == TR_REV);
            end
            MODE_X2B: begin
                step = legal && b_moved;
                down = (tr == TR_REV);
            end
            MODE_X4: begin
                step = legal;
                down = (tr == TR_REV);
            end
            default: begin
                step = 1'b0;
                down = 1'b0;
            end
        endcase
    end

    AST_X2A_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_X2A && !a_moved) |-> !step); // R2
    AST_X2B_IGNORES_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_X2B && !b_moved) |-> !step); // R3

endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              wrap_evt,
    output logic              run_q,
    output logic              pre_q,
    output cnt_mode_e         mode_q,
    output logic [CNT_W-1:0]  ceil_sh_q,
    output logic [CNT_W-1:0]  ceil_act_q,
    output logic              cnt_wr
);

    localparam logic [CNT_W-1:0] CEIL_MAX = '1;

    logic ctrl_wr;
    logic mode_wr;
    logic ceil_wr;
    logic sw_evt;
    logic upd_evt;

    assign ctrl_wr = wr_en && (addr == REG_CTRL);
    assign mode_wr = wr_en && (addr == REG_MODE);
    assign ceil_wr = wr_en && (addr == REG_CEIL);
    assign cnt_wr  = wr_en && (addr == REG_COUNT);
    assign sw_evt  = wr_en && (addr == REG_EVENT) && wdata[0];
    assign upd_evt = sw_evt || wrap_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            pre_q  <= 1'b0;
            mode_q <= MODE_FREE;
        end else begin
            if (ctrl_wr) begin
                run_q <= wdata[CTRL_RUN_BIT];
                pre_q <= wdata[CTRL_PRE_BIT];
            end
            if (mode_wr) begin
                mode_q <= cnt_mode_e'(wdata[1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ceil_sh_q  <= CEIL_MAX;
            ceil_act_q <= CEIL_MAX;
        end else begin
            if (ceil_wr) begin
                ceil_sh_q <= wdata;
            end
            if (ceil_wr && !pre_q) begin
                ceil_act_q <= wdata;
            end else if (upd_evt) begin
                ceil_act_q <= ceil_sh_q;
            end
        end
    end

    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q && !upd_evt) |=> $stable(ceil_act_q)); // R7
    AST_CEIL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ceil_wr && !pre_q) |=> (ceil_act_q == $past(wdata))); // R7
    AST_SW_EVENT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_evt && !ceil_wr) |=> (ceil_act_q == $past(ceil_sh_q))); // R10

endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             down,
    input  logic [CNT_W-1:0] ceil_act,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dir_q,
    output logic             wrap_evt
);

    logic take_step;
    logic at_top;
    logic at_bottom;

    assign take_step = run && step && !cnt_wr;
    assign at_top    = (cnt_q >= ceil_act);
    assign at_bottom = (cnt_q == '0);
    assign wrap_evt  = take_step && (down ? at_bottom : at_top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (cnt_wr) begin
            if (wr_val <= ceil_act) begin
                cnt_q <= wr_val;
            end
        end else if (take_step) begin
            dir_q <= down;
            if (down) begin
                cnt_q <= at_bottom ? ceil_act : cnt_q - 1'b1;
            end else begin
                cnt_q <= at_top ? '0 : cnt_q + 1'b1;
            end
        end
    end

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> ($stable(cnt_q) && $stable(dir_q))); // R5
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !down && !cnt_wr && cnt_q >= ceil_act) |=> (cnt_q == '0)); // R8
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && down && !cnt_wr && cnt_q == '0) |=> (cnt_q == $past(ceil_act))); // R8
    AST_REJECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && wr_val > ceil_act) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              qa_in,
    input  logic              qb_in
);

    localparam int SYNC_STAGES = 2;

    logic [1:0]       ab_s;
    logic             run_q;
    logic             pre_q;
    cnt_mode_e        mode_q;
    logic [CNT_W-1:0] ceil_sh_q;
    logic [CNT_W-1:0] ceil_act_q;
    logic             cnt_wr;
    logic             step;
    logic             down;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             wrap_evt;

    qenc_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({qa_in, qb_in}),
        .d_out (ab_s)
    );

    qenc_decode u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .a_s   (ab_s[1]),
        .b_s   (ab_s[0]),
        .mode  (mode_q),
        .step  (step),
        .down  (down)
    );

    qenc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .wrap_evt   (wrap_evt),
        .run_q      (run_q),
        .pre_q      (pre_q),
        .mode_q     (mode_q),
        .ceil_sh_q  (ceil_sh_q),
        .ceil_act_q (ceil_act_q),
        .cnt_wr     (cnt_wr)
    );

    qenc_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .step     (step),
        .down     (down),
        .ceil_act (ceil_act_q),
        .cnt_wr   (cnt_wr),
        .wr_val   (wdata),
        .cnt_q    (cnt_q),
        .dir_q    (dir_q),
        .wrap_evt (wrap_evt)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_CTRL: begin
                rdata[CTRL_RUN_BIT] = run_q;
                rdata[CTRL_PRE_BIT] = pre_q;
                rdata[CTRL_DIR_BIT] = dir_q;
            end
            REG_MODE:  rdata[1:0] = mode_q;
            REG_COUNT: rdata = cnt_q;
            REG_CEIL:  rdata = ceil_sh_q;
            default:   rdata = '0;
        endcase
    end

    AST_BOTH_FLIP_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_FREE && ab_s[1] != $past(ab_s[1]) && ab_s[0] != $past(ab_s[0]) && !cnt_wr)
        |=> $stable(cnt_q)); // R6
    AST_FREE_DIR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FREE && run_q && !cnt_wr) |=> !dir_q); // R11

endmodule

// File: tb/qenc_counter_bench.sv
module qenc_counter_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = 3'd2;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         qa = 1'b0;
    logic         qb = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string cur_req = "R12";
    int qidx = 0;

    always #10 clk = ~clk;

    qenc_counter #(.CNT_W(W)) u_qenc_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .qa_in (qa),
        .qb_in (qb)
    );

    // Behavioural reference model
    int m_cnt, m_cact, m_csh, m_mode;
    bit m_run, m_pre, m_dir;
    bit m_s1a, m_s1b, m_s2a, m_s2b, m_pa, m_pb;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_cact = 65535; m_csh = 65535; m_mode = 0;
            m_run = 0; m_pre = 0; m_dir = 0;
            m_s1a = 0; m_s1b = 0; m_s2a = 0; m_s2b = 0; m_pa = 0; m_pb = 0;
        end else begin
            bit chA, chB, stp, dn, wrp, swe;
            int old_csh;
            chA = (m_pa != m_s2a);
            chB = (m_pb != m_s2b);
            stp = 0; dn = 0; wrp = 0; swe = 0;
            old_csh = m_csh;
            if (m_mode == 0) begin
                stp = 1;
            end else if (chA && chB) begin
                stp = 0;
            end else if (chA && (m_mode == 1 || m_mode == 3)) begin
                stp = 1; dn = (m_s2a == m_s2b);
            end else if (chB && (m_mode == 2 || m_mode == 3)) begin
                stp = 1; dn = (m_s2b != m_s2a);
            end
            if (wr_en && addr == 3'd2) begin
                if (int'(wdata) <= m_cact) m_cnt = int'(wdata);
            end else if (m_run && stp) begin
                m_dir = dn;
                if (!dn) begin
                    if (m_cnt >= m_cact) begin m_cnt = 0; wrp = 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_cnt = m_cact; wrp = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end
            if (wr_en && addr == 3'd4 && wdata[0]) swe = 1;
            if (wr_en && addr == 3'd3 && !m_pre) m_cact = int'(wdata);
            else if (swe || wrp) m_cact = old_csh;
            if (wr_en && addr == 3'd3) m_csh = int'(wdata);
            if (wr_en && addr == 3'd0) begin m_run = wdata[0]; m_pre = wdata[1]; end
            if (wr_en && addr == 3'd1) m_mode = int'(wdata[1:0]);
            m_pa = m_s2a; m_pb = m_s2b;
            m_s2a = m_s1a; m_s2b = m_s1b;
            m_s1a = qa; m_s1b = qb;
        end
    end

    function automatic int m_read(input logic [2:0] a);
        case (a)
            3'd0: return (int'(m_dir) << 4) | (int'(m_pre) << 1) | int'(m_run);
            3'd1: return m_mode;
            3'd2: return m_cnt;
            3'd3: return m_csh;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
        chk(cur_req, int'(rdata), m_read(addr));
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        addr = a; wdata = W'(d); wr_en = 1'b1;
        cyc();
        wr_en = 1'b0; addr = 3'd2;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input int exp);
        addr = a;
        #1;
        chk(req, int'(rdata), exp);
        addr = 3'd2;
        #1;
    endtask

    // Forward order of {A,B}: 00,10,11,01
    task automatic quad(input bit fwd, input int n);
        for (int i = 0; i < n; i++) begin
            qidx = fwd ? (qidx + 1) % 4 : (qidx + 3) % 4;
            case (qidx)
                0: begin qa = 0; qb = 0; end
                1: begin qa = 1; qb = 0; end
                2: begin qa = 1; qb = 1; end
                default: begin qa = 0; qb = 1; end
            endcase
            repeat (4) cyc();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R12 reset values, R13 map, R10 event reads 0
        rd("R12", 3'd0, 0);
        rd("R12", 3'd1, 0);
        rd("R12", 3'd2, 0);
        rd("R12", 3'd3, 65535);
        rd("R10", 3'd4, 0);

        cur_req = "R1";
        wr(3'd0, 1);
        repeat (10) cyc();
        rd("R1", 3'd2, 10);
        rd("R11", 3'd0, 1);

        cur_req = "R5";
        wr(3'd0, 0);
        repeat (5) cyc();
        rd("R5", 3'd2, 11);

        cur_req = "R9";
        wr(3'd3, 9);
        wr(3'd2, 3);
        rd("R9", 3'd2, 3);
        wr(3'd2, 12);
        rd("R9", 3'd2, 3);
        wr(3'd2, 9);
        rd("R9", 3'd2, 9);

        cur_req = "R8";
        wr(3'd0, 1);
        repeat (12) cyc();
        rd("R8", 3'd2, 1);
        wr(3'd0, 0);
        wr(3'd2, 0);

        cur_req = "R4";
        wr(3'd1, 3);
        wr(3'd0, 1);
        quad(1, 8);
        rd("R4", 3'd2, 8);
        rd("R11", 3'd0, 1);
        quad(0, 10);
        rd("R8", 3'd2, 8);
        rd("R11", 3'd0, 17);

        cur_req = "R2";
        wr(3'd0, 0);
        wr(3'd2, 0);
        wr(3'd1, 1);
        wr(3'd0, 1);
        quad(1, 8);
        rd("R2", 3'd2, 4);
        quad(0, 2);
        rd("R2", 3'd2, 3);

        cur_req = "R3";
        wr(3'd1, 2);
        quad(1, 4);
        rd("R3", 3'd2, 5);

        cur_req = "R6";
        wr(3'd1, 3);
        qa = ~qa; qb = ~qb;
        qidx = (qidx + 2) % 4;
        repeat (4) cyc();
        rd("R6", 3'd2, 5);
        qa = ~qa;
        qidx = (qb) ? 3 : 0;
        if (qa && qb) qidx = 2;
        if (qa && !qb) qidx = 1;
        // three edges until visible
        @(posedge clk); #2; chk("R6", int'(rdata), 5);
        @(posedge clk); #2; chk("R6", int'(rdata), 5);
        @(posedge clk); #2; chk("R6", int'(rdata), m_read(3'd2));
        rd("R6", 3'd2, 6);

        cur_req = "R7";
        wr(3'd0, 0);
        wr(3'd2, 0);
        wr(3'd1, 0);
        wr(3'd0, 2);
        wr(3'd3, 4);
        rd("R7", 3'd3, 4);
        wr(3'd0, 3);
        repeat (18) cyc();
        rd("R7", 3'd2, 3);

        cur_req = "R10";
        wr(3'd0, 2);
        rd("R10", 3'd2, 4);
        wr(3'd3, 7);
        wr(3'd2, 6);
        rd("R9", 3'd2, 4);
        wr(3'd4, 1);
        wr(3'd2, 6);
        rd("R10", 3'd2, 6);
        rd("R10", 3'd4, 0);
        repeat (3) cyc();

        finish_run();
    end

endmodule